// File: doc/BRIEF.md
# Infrared Frame FIFO Abort Controller

This block sits between a host-side byte source and a fast infrared framer. It buffers bytes in a 128-entry first-in first-out store. In transmit mode the host fills the store and the framer drains it. In receive mode the framer fills the store and the host drains it. The read side always sees the oldest byte on `headData`, so each read strobe consumes the byte shown in that cycle.

The controller decides how every message ends. A transmit read from an empty store is an underrun. The underrun ends the message normally when the host has flagged the end of valid data. It also ends normally when a loaded byte-size counter has reached zero on the last read. In every other case the underrun aborts the frame. The controller also handles a forced abort, receive overruns, payload framing errors and received checksum errors. It raises sticky status flags that the host clears by writing ones.

Top module: `ir_frame_fifo_ctrl`

## Requirements
- R1: The store holds exactly 128 bytes and returns them in write order on `headData`. A write while `fifoFull` is high is dropped.
- R2: `fifoFull` implies `fifoNotEmpty`. A one-cycle `fifoResetReq` pulse empties the store, so both flags are low in the following cycle.
- R3: `fcsErr` in receive mode (`txMode`=0) sets `crcErr` at the next clock edge.
- R4: A framer write in receive mode while `fifoFull` is high is dropped, and `frameAbort` is set at the next clock edge.
- R5: `payloadErr` in receive mode sets `frameAbort` at the next clock edge.
- R6: A framer read from an empty store in transmit mode, with `dataDone` low and the size counter not exhausted, sets both `frameAbort` and `eomFlag`.
- R7: The size counter is loaded from `sizeValue` by `sizeLoad` and counts down on each transmit read. Once a read takes it from 1 to 0, the next underrun sets `eomFlag` without `frameAbort`, even when `dataDone` is low.
- R8: An underrun while `dataDone` is high sets `eomFlag` without `frameAbort`.
- R9: When `abortSet` is raised during an active transmit message (at least one byte read since the last end), the store is flushed and `eomFlag` and `frameAbort` are set. While no message is active, the pending abort leaves the store contents and `frameAbort` unchanged.
- R10: `abortPending` is set by `abortSet` and cleared by `eofStrobe`.
- R11: `dmaTc` sets `dataDone` in transmit mode. In receive mode `dmaTc` leaves `dataDone` unchanged.
- R12: At an end of message (`eofStrobe`, an underrun, or a forced abort), `dataDone` clears only if the store is empty at that point. Otherwise it stays high.
- R13: `clrFlags` bit 0 clears `crcErr`, bit 1 clears `frameAbort` and bit 2 clears `eomFlag`. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txMode | input | 1 | 1 = transmit, 0 = receive |
| hostWrEn | input | 1 | Host or DMA byte write (transmit) |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host or DMA byte read (receive) |
| frmWrEn | input | 1 | Framer byte write (receive) |
| frmWrData | input | 8 | Framer write byte |
| frmRdEn | input | 1 | Framer byte read (transmit) |
| headData | output | 8 | Oldest byte in the store |
| dmaTc | input | 1 | DMA terminal-count strobe |
| sizeLoad | input | 1 | Load the transmit size counter |
| sizeValue | input | 16 | Size counter load value |
| fcsErr | input | 1 | Received checksum failure strobe |
| payloadErr | input | 1 | Received payload framing error strobe |
| eofStrobe | input | 1 | End-of-frame strobe |
| abortSet | input | 1 | Request a forced abort |
| dataDoneSet | input | 1 | Host marks end of valid transmit data |
| fifoResetReq | input | 1 | Flush the store |
| clrFlags | input | 3 | Write-one-to-clear: {eom, frameAbort, crc} |
| fifoFull | output | 1 | Store holds 128 bytes |
| fifoNotEmpty | output | 1 | Store holds at least one byte |
| eomFlag | output | 1 | Sticky end-of-message |
| crcErr | output | 1 | Sticky checksum error |
| frameAbort | output | 1 | Sticky frame abort |
| abortPending | output | 1 | Abort control bit |
| dataDone | output | 1 | End-of-valid-data qualifier |

## Verification
Transmit underruns are produced three ways so that each path can be told apart from the others: with no qualifier (abort), after the size counter runs out (clean end), and with the data-done qualifier set (clean end). A forced abort is issued once while idle and once after a byte has been read. This shows the flush depends on message activity. Receive runs fill the store past capacity and inject framing and checksum strobes. Terminal count is pulsed in both directions, and end-of-frame is given once with bytes still stored, which shows when data-done survives.

// File: rtl/ir_fifo_pkg.sv
package ir_fifo_pkg;
  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic sizeDec;
    logic sizeClr;
  } dpCtl_t;
endpackage

// File: rtl/ir_fifo_datapath.sv
module ir_fifo_datapath
  import ir_fifo_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sizeLoad,
  input  logic [SIZE_W-1:0] sizeValue,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty,
  output logic              sizeDone
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic [SIZE_W-1:0] sizeCnt;

  // Storage has no reset; only the pointers define validity.
  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);

  // Transmit byte-size counter and its exhausted marker.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeCnt  <= '0;
      sizeDone <= 1'b0;
    end else if (sizeLoad) begin
      sizeCnt  <= sizeValue;
      sizeDone <= 1'b0;
    end else begin
      if (ctl.sizeDec && sizeCnt != '0) sizeCnt <= sizeCnt - 1'b1;
      if (ctl.sizeClr)
        sizeDone <= 1'b0;
      else if (ctl.sizeDec && sizeCnt == SIZE_W'(1))
        sizeDone <= 1'b1;
    end
  end
endmodule

// File: rtl/ir_fifo_control.sv
module ir_fifo_control
  import ir_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txMode,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic       frmWrEn,
  input  logic       frmRdEn,
  input  logic       dmaTc,
  input  logic       fcsErr,
  input  logic       payloadErr,
  input  logic       eofStrobe,
  input  logic       abortSet,
  input  logic       dataDoneSet,
  input  logic       fifoResetReq,
  input  logic [2:0] clrFlags,
  input  logic       full,
  input  logic       empty,
  input  logic       sizeDone,
  output dpCtl_t     ctl,
  output logic       eomFlag,
  output logic       crcErr,
  output logic       frameAbort,
  output logic       abortPending,
  output logic       dataDone
);
  logic txActive;
  logic pushReq, popReq;
  logic forcedAbort, flushNow;
  logic underrun, underrunAbort, overrun, rxAbort;
  logic abortEvt, eomEvt, crcEvt;

  always_comb begin
    pushReq       = txMode ? hostWrEn : frmWrEn;
    popReq        = txMode ? frmRdEn  : hostRdEn;
    forcedAbort   = abortPending && txMode && txActive;
    flushNow      = fifoResetReq || forcedAbort;
    underrun      = txMode && frmRdEn && empty && !flushNow;
    underrunAbort = underrun && !dataDone && !sizeDone;
    overrun       = !txMode && frmWrEn && full;
    rxAbort       = overrun || (!txMode && payloadErr);
    abortEvt      = forcedAbort || underrunAbort || rxAbort;
    eomEvt        = forcedAbort || underrun || eofStrobe;
    crcEvt        = !txMode && fcsErr;

    ctl.flush   = flushNow;
    ctl.push    = pushReq && !full && !flushNow;
    ctl.pop     = popReq && !empty && !flushNow;
    ctl.sizeDec = ctl.pop && txMode;
    ctl.sizeClr = eomEvt;
  end

  // Message activity: starts with the first transmit read, ends at any end of message.
  always_ff @(posedge clk) begin
    if (!rstN)                  txActive <= 1'b0;
    else if (eomEvt)            txActive <= 1'b0;
    else if (ctl.pop && txMode) txActive <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          abortPending <= 1'b0;
    else if (abortSet)  abortPending <= 1'b1;
    else if (eofStrobe) abortPending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dataDone <= 1'b0;
    else if (dataDoneSet || (dmaTc && txMode))
      dataDone <= 1'b1;
    else if (eomEvt && (empty || flushNow))
      dataDone <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eomFlag    <= 1'b0;
      crcErr     <= 1'b0;
      frameAbort <= 1'b0;
    end else begin
      if (eomEvt)           eomFlag <= 1'b1;
      else if (clrFlags[2]) eomFlag <= 1'b0;
      if (crcEvt)           crcErr <= 1'b1;
      else if (clrFlags[0]) crcErr <= 1'b0;
      if (abortEvt)         frameAbort <= 1'b1;
      else if (clrFlags[1]) frameAbort <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_frame_fifo_ctrl.sv
module ir_frame_fifo_ctrl
  import ir_fifo_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdEn,
  input  logic              frmWrEn,
  input  logic [DATA_W-1:0] frmWrData,
  input  logic              frmRdEn,
  output logic [DATA_W-1:0] headData,
  input  logic              dmaTc,
  input  logic              sizeLoad,
  input  logic [SIZE_W-1:0] sizeValue,
  input  logic              fcsErr,
  input  logic              payloadErr,
  input  logic              eofStrobe,
  input  logic              abortSet,
  input  logic              dataDoneSet,
  input  logic              fifoResetReq,
  input  logic [2:0]        clrFlags,
  output logic              fifoFull,
  output logic              fifoNotEmpty,
  output logic              eomFlag,
  output logic              crcErr,
  output logic              frameAbort,
  output logic              abortPending,
  output logic              dataDone
);
  dpCtl_t            ctl;
  logic              full, empty, sizeDone;
  logic [DATA_W-1:0] wrData;

  assign wrData = txMode ? hostWrData : frmWrData;

  ir_fifo_control u_control (
    .clk(clk), .rstN(rstN), .txMode(txMode),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .frmWrEn(frmWrEn), .frmRdEn(frmRdEn),
    .dmaTc(dmaTc), .fcsErr(fcsErr), .payloadErr(payloadErr),
    .eofStrobe(eofStrobe), .abortSet(abortSet), .dataDoneSet(dataDoneSet),
    .fifoResetReq(fifoResetReq), .clrFlags(clrFlags),
    .full(full), .empty(empty), .sizeDone(sizeDone),
    .ctl(ctl), .eomFlag(eomFlag), .crcErr(crcErr), .frameAbort(frameAbort),
    .abortPending(abortPending), .dataDone(dataDone)
  );

  ir_fifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .sizeLoad(sizeLoad), .sizeValue(sizeValue),
    .rdData(headData), .full(full), .empty(empty), .sizeDone(sizeDone)
  );

  assign fifoFull     = full;
  assign fifoNotEmpty = !empty;
endmodule

// File: rtl/ir_frame_fifo_ctrl_checker.sv
module ir_frame_fifo_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txMode,
  input logic       frmWrEn,
  input logic       dmaTc,
  input logic       fcsErr,
  input logic       payloadErr,
  input logic       eofStrobe,
  input logic       abortSet,
  input logic       dataDoneSet,
  input logic       fifoResetReq,
  input logic [2:0] clrFlags,
  input logic       fifoFull,
  input logic       fifoNotEmpty,
  input logic       crcErr,
  input logic       frameAbort,
  input logic       abortPending,
  input logic       dataDone
);
  assert_full_implies_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> fifoNotEmpty);

  assert_reset_empties_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoResetReq |=> (!fifoNotEmpty && !fifoFull));

  assert_crc_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && fcsErr) |=> crcErr);

  assert_overrun_aborts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && frmWrEn && fifoFull) |=> frameAbort);

  assert_payload_aborts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && payloadErr) |=> frameAbort);

  assert_eof_clears_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (eofStrobe && !abortSet) |=> !abortPending);

  assert_tc_ignored_rx_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && dmaTc && !dataDoneSet && !dataDone) |=> !dataDone);

  assert_crc_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !clrFlags[0]) |=> crcErr);
endmodule

bind ir_frame_fifo_ctrl ir_frame_fifo_ctrl_checker u_checker (
  .clk(clk), .rstN(rstN), .txMode(txMode), .frmWrEn(frmWrEn), .dmaTc(dmaTc),
  .fcsErr(fcsErr), .payloadErr(payloadErr), .eofStrobe(eofStrobe),
  .abortSet(abortSet), .dataDoneSet(dataDoneSet), .fifoResetReq(fifoResetReq),
  .clrFlags(clrFlags), .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty),
  .crcErr(crcErr), .frameAbort(frameAbort), .abortPending(abortPending),
  .dataDone(dataDone)
);

// File: tb/ir_frame_fifo_ctrl_bench.sv
module ir_frame_fifo_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        txMode, hostWrEn, hostRdEn, frmWrEn, frmRdEn;
  logic [7:0]  hostWrData, frmWrData, headData;
  logic        dmaTc, sizeLoad, fcsErr, payloadErr, eofStrobe;
  logic        abortSet, dataDoneSet, fifoResetReq;
  logic [15:0] sizeValue;
  logic [2:0]  clrFlags;
  logic        fifoFull, fifoNotEmpty, eomFlag, crcErr, frameAbort;
  logic        abortPending, dataDone;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ir_frame_fifo_ctrl u_ir_frame_fifo_ctrl (
    .clk(clk), .rstN(rstN), .txMode(txMode),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .frmWrEn(frmWrEn), .frmWrData(frmWrData), .frmRdEn(frmRdEn),
    .headData(headData), .dmaTc(dmaTc), .sizeLoad(sizeLoad), .sizeValue(sizeValue),
    .fcsErr(fcsErr), .payloadErr(payloadErr), .eofStrobe(eofStrobe),
    .abortSet(abortSet), .dataDoneSet(dataDoneSet), .fifoResetReq(fifoResetReq),
    .clrFlags(clrFlags), .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty),
    .eomFlag(eomFlag), .crcErr(crcErr), .frameAbort(frameAbort),
    .abortPending(abortPending), .dataDone(dataDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] b);
    hostWrEn = 1'b1; hostWrData = b; tick(); hostWrEn = 1'b0;
  endtask

  task automatic framerWrite(input logic [7:0] b);
    frmWrEn = 1'b1; frmWrData = b; tick(); frmWrEn = 1'b0;
  endtask

  task automatic framerRead();
    frmRdEn = 1'b1; tick(); frmRdEn = 1'b0;
  endtask

  task automatic pulseEof();
    eofStrobe = 1'b1; tick(); eofStrobe = 1'b0;
  endtask

  task automatic pulseFlush();
    fifoResetReq = 1'b1; tick(); fifoResetReq = 1'b0;
  endtask

  task automatic clearAll();
    clrFlags = 3'b111; tick(); clrFlags = 3'b000;
  endtask

  task automatic testResetState();
    check("R2 reset notEmpty", 32'(fifoNotEmpty), 0);
    check("R2 reset full", 32'(fifoFull), 0);
    check("R13 reset eom", 32'(eomFlag), 0);
    check("R13 reset crc", 32'(crcErr), 0);
    check("R13 reset abort", 32'(frameAbort), 0);
    check("R11 reset dataDone", 32'(dataDone), 0);
  endtask

  task automatic testFillOrder();
    txMode = 1'b1;
    for (int i = 0; i < 128; i++) hostWrite(8'(i));
    check("R1 full after 128", 32'(fifoFull), 1);
    hostWrite(8'hEE);
    for (int i = 0; i < 128; i++) begin
      check("R1 order", 32'(headData), 32'(i));
      framerRead();
    end
    check("R1 extra write dropped", 32'(fifoNotEmpty), 0);
    check("R6 no abort on drain", 32'(frameAbort), 0);
    pulseEof();
    check("R12 eof sets eom", 32'(eomFlag), 1);
    clearAll();
    check("R13 eom cleared", 32'(eomFlag), 0);
  endtask

  task automatic testFlush();
    txMode = 1'b1;
    for (int i = 0; i < 3; i++) hostWrite(8'h10);
    check("R2 notEmpty before flush", 32'(fifoNotEmpty), 1);
    pulseFlush();
    check("R2 flush clears notEmpty", 32'(fifoNotEmpty), 0);
    for (int i = 0; i < 128; i++) hostWrite(8'h20);
    check("R2 full before flush", 32'(fifoFull), 1);
    pulseFlush();
    check("R2 flush clears full", 32'(fifoFull), 0);
    check("R2 flush clears notEmpty 2", 32'(fifoNotEmpty), 0);
  endtask

  task automatic testUnderrunAbort();
    txMode = 1'b1;
    hostWrite(8'h31); hostWrite(8'h32);
    framerRead(); framerRead();
    check("R6 no abort yet", 32'(frameAbort), 0);
    framerRead();
    check("R6 underrun abort", 32'(frameAbort), 1);
    check("R6 underrun eom", 32'(eomFlag), 1);
    clearAll();
  endtask

  task automatic testSizeEnd();
    txMode = 1'b1;
    sizeLoad = 1'b1; sizeValue = 16'd3; tick(); sizeLoad = 1'b0;
    for (int i = 0; i < 3; i++) hostWrite(8'h40);
    for (int i = 0; i < 3; i++) framerRead();
    framerRead();
    check("R7 size end eom", 32'(eomFlag), 1);
    check("R7 size end no abort", 32'(frameAbort), 0);
    clearAll();
  endtask

  task automatic testDataDone();
    txMode = 1'b0;
    dmaTc = 1'b1; tick(); dmaTc = 1'b0;
    check("R11 tc ignored in receive", 32'(dataDone), 0);
    txMode = 1'b1;
    dmaTc = 1'b1; tick(); dmaTc = 1'b0;
    check("R11 tc sets dataDone", 32'(dataDone), 1);
    hostWrite(8'h51); hostWrite(8'h52);
    framerRead(); framerRead(); framerRead();
    check("R8 clean end eom", 32'(eomFlag), 1);
    check("R8 clean end no abort", 32'(frameAbort), 0);
    check("R12 dataDone cleared when empty", 32'(dataDone), 0);
    clearAll();
    dataDoneSet = 1'b1; tick(); dataDoneSet = 1'b0;
    hostWrite(8'h53); hostWrite(8'h54);
    pulseEof();
    check("R12 dataDone kept with data", 32'(dataDone), 1);
    pulseFlush();
    pulseEof();
    check("R12 dataDone cleared after flush", 32'(dataDone), 0);
    clearAll();
  endtask

  task automatic testForcedAbort();
    txMode = 1'b1;
    hostWrite(8'h61); hostWrite(8'h62);
    abortSet = 1'b1; tick(); abortSet = 1'b0;
    check("R10 abortPending set", 32'(abortPending), 1);
    tick(); tick(); tick();
    check("R9 idle abort keeps data", 32'(fifoNotEmpty), 1);
    check("R9 idle abort no flag", 32'(frameAbort), 0);
    pulseEof();
    check("R10 eof clears abortPending", 32'(abortPending), 0);
    clearAll();
    check("R9 head after idle abort", 32'(headData), 32'h61);
    framerRead();
    abortSet = 1'b1; tick(); abortSet = 1'b0;
    tick();
    check("R9 forced abort flushes", 32'(fifoNotEmpty), 0);
    check("R9 forced abort flag", 32'(frameAbort), 1);
    check("R9 forced abort eom", 32'(eomFlag), 1);
    pulseEof();
    check("R10 eof clears after abort", 32'(abortPending), 0);
    clearAll();
  endtask

  task automatic testReceive();
    txMode = 1'b0;
    pulseFlush();
    for (int i = 0; i < 128; i++) framerWrite(8'(i + 1));
    check("R1 receive full", 32'(fifoFull), 1);
    check("R4 no abort at full", 32'(frameAbort), 0);
    framerWrite(8'hAA);
    check("R4 overrun abort", 32'(frameAbort), 1);
    check("R4 head is first byte", 32'(headData), 1);
    hostRdEn = 1'b1; tick(); hostRdEn = 1'b0;
    check("R1 host read advances", 32'(headData), 2);
    check("R4 overrun byte dropped", 32'(fifoFull), 0);
    clrFlags = 3'b010; tick(); clrFlags = 3'b000;
    check("R13 abort cleared", 32'(frameAbort), 0);
    payloadErr = 1'b1; tick(); payloadErr = 1'b0;
    check("R5 payload error abort", 32'(frameAbort), 1);
    fcsErr = 1'b1; tick(); fcsErr = 1'b0;
    check("R3 crc set", 32'(crcErr), 1);
    clrFlags = 3'b011; tick(); clrFlags = 3'b000;
    check("R13 crc cleared", 32'(crcErr), 0);
    check("R13 abort cleared 2", 32'(frameAbort), 0);
    fcsErr = 1'b1; clrFlags = 3'b001; tick(); fcsErr = 1'b0; clrFlags = 3'b000;
    check("R13 set wins over clear", 32'(crcErr), 1);
    clearAll();
  endtask

  initial begin
    rstN = 1'b0; txMode = 1'b1;
    hostWrEn = 0; hostRdEn = 0; frmWrEn = 0; frmRdEn = 0;
    hostWrData = 0; frmWrData = 0; dmaTc = 0; sizeLoad = 0; sizeValue = 0;
    fcsErr = 0; payloadErr = 0; eofStrobe = 0; abortSet = 0; dataDoneSet = 0;
    fifoResetReq = 0; clrFlags = 3'b000;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testResetState();
    testFillOrder();
    testFlush();
    testUnderrunAbort();
    testSizeEnd();
    testDataDone();
    testForcedAbort();
    testReceive();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule